// File: doc/BRIEF.md
# Dual-CPU Interrupt Level Encoder

This block turns a set of pending interrupt sources into an encoded request level for each of two processors, a master and a slave. Each processor sees the OR of a shared pending vector and its own private pending vector. It then filters that vector through its own mask and reports the position of the highest surviving source as an even-numbered level. A wake flag per processor tells surrounding logic that the processor has work to do. Circuits that set or clear the pending flags, acknowledge cycles and the processor cores lie outside the block.

The source vectors are eight bits wide. A four-bit mask enables sources 3 to 6: mask bit k enables source k+3. Source 7 is the reset-interrupt source and is always enabled. Sources 0 to 2 can never be enabled. The encoding is computed combinationally and registered, so the outputs follow the inputs one clock later.

Top module: `dcil_encoder`

## Requirements
- R1: For each processor the candidate vector is the bitwise OR of `shared_pend` and that processor's private pending vector. A source pending in either one counts.
- R2: Mask bit k (k = 0..3) enables source bit k+3. Source bits 0, 1 and 2 never affect any output, whatever the mask holds.
- R3: Source bit 7 (the reset-interrupt source) is enabled regardless of the mask. When it is pending the level is 14.
- R4: The level equals twice the index of the highest enabled pending source bit. When no enabled bit is pending the level is 0.
- R5: The master level depends only on `shared_pend`, `m_pend` and `m_mask`. The slave level depends only on `shared_pend`, `s_pend` and `s_mask`.
- R6: `wake[0]` is 1 exactly when `m_level` is nonzero. `wake[1]` is 1 exactly when `s_level` is nonzero.
- R7: The outputs reflect the inputs present at the previous rising clock edge, with one cycle of latency.
- R8: While `rst` is high at a rising edge, both levels and both wake bits are cleared at that edge.
- R9: Every level is even and lies in the range 0 to 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shared_pend | input | 8 | Pending sources seen by both processors; bit 7 is the reset source |
| m_pend | input | 8 | Pending sources private to the master |
| s_pend | input | 8 | Pending sources private to the slave |
| m_mask | input | 4 | Master enable mask; bit k enables source k+3 |
| s_mask | input | 4 | Slave enable mask; bit k enables source k+3 |
| m_level | output | 4 | Registered master request level |
| s_level | output | 4 | Registered slave request level |
| wake | output | 2 | Bit 0: master has a nonzero level; bit 1: slave has a nonzero level |

## Verification
The assertions check the following on every cycle: levels are even and bounded, each wake bit matches its level, reset clears both outputs, a pending reset source forces level 14 one cycle later, and an empty enabled vector yields level 0. Only the bench scenarios can show the exact mapping from mask bit to source bit, the priority among several enabled sources, and that the two processors do not disturb each other. The bench checks these against a reference highest-bit model over directed and random patterns.

// File: rtl/dcil_pkg.sv
package dcil_pkg;
    localparam int SRC_W      = 8;
    localparam int MASK_W     = 4;
    localparam int MASK_SHIFT = 3;
    localparam int RST_BIT    = 7;
    localparam int NCPU       = 2;
    localparam int LVL_W      = $clog2(2 * (SRC_W - 1) + 1);

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef struct packed {
        lvl_t [NCPU-1:0]  lvl;
        logic [NCPU-1:0]  wake;
    } out_t;
endpackage

// File: rtl/dcil_gate.sv
// Per-processor source gating: combine shared and private flags, apply mask.
module dcil_gate #(
    parameter int SRC_W      = dcil_pkg::SRC_W,
    parameter int MASK_W     = dcil_pkg::MASK_W,
    parameter int MASK_SHIFT = dcil_pkg::MASK_SHIFT,
    parameter int RST_BIT    = dcil_pkg::RST_BIT
) (
    input  logic [SRC_W-1:0]  shared_i,
    input  logic [SRC_W-1:0]  own_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [SRC_W-1:0]  active_o
);
    logic [SRC_W-1:0] enable_d;
    logic [SRC_W-1:0] cand_d;

    always_comb begin
        enable_d = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (i + MASK_SHIFT < SRC_W) enable_d[i + MASK_SHIFT] = mask_i[i];
        end
        enable_d[RST_BIT] = 1'b1;
        cand_d   = shared_i | own_i;
        active_o = cand_d & enable_d;
    end
endmodule

// File: rtl/dcil_prio.sv
// Highest-set-bit encoder producing a doubled index.
module dcil_prio #(
    parameter int SRC_W = dcil_pkg::SRC_W,
    parameter int LVL_W = dcil_pkg::LVL_W
) (
    input  logic [SRC_W-1:0] vec_i,
    output logic [LVL_W-1:0] level_o
);
    localparam int IDX_W = $clog2(SRC_W);
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = '0;
        for (int i = 1; i < SRC_W; i++) begin
            if (vec_i[i]) idx_d = IDX_W'(i);
        end
        level_o = LVL_W'({idx_d, 1'b0});
    end
endmodule

// File: rtl/dcil_encoder.sv
module dcil_encoder
    import dcil_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  shared_pend,
    input  logic [7:0]  m_pend,
    input  logic [7:0]  s_pend,
    input  logic [3:0]  m_mask,
    input  logic [3:0]  s_mask,
    output logic [3:0]  m_level,
    output logic [3:0]  s_level,
    output logic [1:0]  wake
);
    src_t  [NCPU-1:0] own_pend;
    mask_t [NCPU-1:0] cpu_mask;
    src_t  [NCPU-1:0] active;
    lvl_t  [NCPU-1:0] lvl_comb;

    out_t out_d, out_q;

    assign own_pend[0] = m_pend;
    assign own_pend[1] = s_pend;
    assign cpu_mask[0] = m_mask;
    assign cpu_mask[1] = s_mask;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        dcil_gate u_gate (
            .shared_i (shared_pend),
            .own_i    (own_pend[c]),
            .mask_i   (cpu_mask[c]),
            .active_o (active[c])
        );
        dcil_prio u_prio (
            .vec_i   (active[c]),
            .level_o (lvl_comb[c])
        );
    end

    always_comb begin
        out_d = out_q;
        for (int c = 0; c < NCPU; c++) begin
            out_d.lvl[c]  = lvl_comb[c];
            out_d.wake[c] = |active[c][SRC_W-1:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign m_level = out_q.lvl[0];
    assign s_level = out_q.lvl[1];
    assign wake    = out_q.wake;

    // Assertion support: marks that one non-reset edge has loaded the outputs.
    logic primed_q;
    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    // R9
    level_even_chk: assert property (@(posedge clk) disable iff (rst)
        (m_level[0] == 1'b0) && (s_level[0] == 1'b0));

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (m_level <= 4'd14) && (s_level <= 4'd14));

    // R6
    wake_match_chk: assert property (@(posedge clk) disable iff (rst)
        (wake[0] == (m_level != 4'd0)) && (wake[1] == (s_level != 4'd0)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (m_level == 4'd0) && (s_level == 4'd0) && (wake == 2'b00));

    // R3
    rst_src_m_chk: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(shared_pend[7] | m_pend[7]) |-> (m_level == 4'd14));

    // R3
    rst_src_s_chk: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(shared_pend[7] | s_pend[7]) |-> (s_level == 4'd14));

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        primed_q && $past(((shared_pend | m_pend) & {1'b1, m_mask, 3'b000}) == 8'h00)
        |-> (m_level == 4'd0));
endmodule

// File: tb/dcil_encoder_test.sv
module dcil_encoder_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] shared_pend, m_pend, s_pend;
    logic [3:0] m_mask, s_mask;
    logic [3:0] m_level, s_level;
    logic [1:0] wake;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    dcil_encoder uut (
        .clk(clk), .rst(rst), .shared_pend(shared_pend), .m_pend(m_pend),
        .s_pend(s_pend), .m_mask(m_mask), .s_mask(s_mask),
        .m_level(m_level), .s_level(s_level), .wake(wake)
    );

    function automatic logic [3:0] ref_lvl(input logic [7:0] sh, input logic [7:0] own,
                                           input logic [3:0] mk);
        logic [7:0] v;
        logic [3:0] r;
        v = (sh | own) & ((8'(mk) << 3) | 8'h80);
        r = 4'd0;
        for (int i = 1; i < 8; i++) if (v[i]) r = 4'(2 * i);
        return r;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, let one rising edge register, sample at next negedge.
    task automatic apply(input string tag, input logic [7:0] sh, input logic [7:0] mp,
                         input logic [7:0] sp, input logic [3:0] mm, input logic [3:0] sm);
        logic [3:0] em, es;
        @(negedge clk);
        shared_pend = sh; m_pend = mp; s_pend = sp; m_mask = mm; s_mask = sm;
        @(negedge clk);
        em = ref_lvl(sh, mp, mm);
        es = ref_lvl(sh, sp, sm);
        check({tag, " m_level"}, m_level, em);
        check({tag, " s_level"}, s_level, es);
        check({tag, " R6 wake"}, {2'b00, wake}, {2'b00, (es != 0), (em != 0)});
    endtask

    task automatic t_reset;
        @(negedge clk);
        shared_pend = 8'hFF; m_pend = 8'hFF; s_pend = 8'hFF; m_mask = 4'hF; s_mask = 4'hF;
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset m_level", m_level, 4'd0);
        check("R8 reset s_level", s_level, 4'd0);
        check("R8 reset wake", {2'b00, wake}, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 after reset m_level", m_level, 4'd14);
    endtask

    task automatic t_or_sources;
        apply("R1 shared only", 8'h10, 8'h00, 8'h00, 4'hF, 4'hF);
        apply("R1 private only", 8'h00, 8'h20, 8'h08, 4'hF, 4'hF);
        apply("R1 both", 8'h08, 8'h40, 8'h00, 4'hF, 4'hF);
    endtask

    task automatic t_mask_map;
        for (int k = 0; k < 4; k++) begin
            apply("R2 mask bit on", 8'h00, 8'(1 << (k + 3)), 8'(1 << (k + 3)),
                  4'(1 << k), 4'(1 << k));
            check("R2 mapped level", m_level, 4'(2 * (k + 3)));
            apply("R2 mask bit off", 8'h00, 8'(1 << (k + 3)), 8'h00, ~4'(1 << k), 4'hF);
        end
        apply("R2 low bits ignored", 8'h07, 8'h07, 8'h07, 4'hF, 4'hF);
        check("R2 low bits level zero", m_level, 4'd0);
    endtask

    task automatic t_reset_source;
        apply("R3 rst src shared mask0", 8'h80, 8'h00, 8'h00, 4'h0, 4'h0);
        check("R3 master 14", m_level, 4'd14);
        check("R3 slave 14", s_level, 4'd14);
        apply("R3 rst src private", 8'h00, 8'h80, 8'h00, 4'h0, 4'hF);
    endtask

    task automatic t_priority;
        apply("R4 highest wins", 8'h00, 8'h78, 8'h28, 4'hF, 4'hF);
        apply("R4 masked top", 8'h00, 8'h78, 8'h78, 4'h7, 4'h3);
        apply("R4 none", 8'h00, 8'h00, 8'h00, 4'hF, 4'hF);
    endtask

    task automatic t_independent;
        apply("R5 master only", 8'h00, 8'h40, 8'h00, 4'hF, 4'hF);
        check("R5 slave untouched", s_level, 4'd0);
        apply("R5 slave only", 8'h00, 8'h00, 8'h20, 4'hF, 4'hF);
        check("R5 master untouched", m_level, 4'd0);
        apply("R5 masks differ", 8'h50, 8'h00, 8'h00, 4'h2, 4'h8);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r0, r1;
            r0 = $urandom; r1 = $urandom;
            apply("R4 R9 random", r0[7:0], r0[15:8], r0[23:16], r1[3:0], r1[7:4]);
            check("R9 even", {3'b000, m_level[0]}, 4'd0);
        end
    endtask

    initial begin
        rst = 1'b1;
        shared_pend = '0; m_pend = '0; s_pend = '0; m_mask = '0; s_mask = '0;
        repeat (2) @(negedge clk);
        t_reset();
        t_or_sources();
        t_mask_map();
        t_reset_source();
        t_priority();
        t_independent();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule